// File: doc/BRIEF.md
# Data-Processing ALU with Condition-Flag Update

This block is the arithmetic and logic stage of a 32-bit integer core. It takes a 4-bit operation code and two operands. The first operand comes from a register read port. The second has already passed through a barrel shifter, and that shifter's carry output arrives alongside it. The block returns a 32-bit result, a strobe that says whether the result should be written to the destination register, and the next value of the four condition flags: negative, zero, carry and overflow.

The block is purely combinational, so its outputs settle in the same cycle its inputs are presented. All six arithmetic forms share one carry-propagate adder. Swapping and inverting the adder's inputs, together with the choice of carry-in, turns it into add, subtract, reverse subtract, or one of their carry-chained variants. Four opcodes only compare or test: they compute a value and may change the flags, but they never request a write. The flags change only when the set-flags input is high.

Top module: `dp_alu`

## Requirements
- R1: Opcode 4'h4 (add) gives op_a+op_b, 4'h2 (subtract) gives op_a-op_b, and 4'h3 (reverse subtract) gives op_b-op_a, all modulo 2^32.
- R2: Opcode 4'h5 gives op_a+op_b+C, 4'h6 gives op_a-op_b-(1-C), and 4'h7 gives op_b-op_a-(1-C), where C is flags_in[1].
- R3: Opcodes 4'h0 (AND), 4'h1 (XOR), 4'hC (OR), 4'hE (op_a AND NOT op_b), 4'hD (pass op_b) and 4'hF (NOT op_b) produce the named logical result.
- R4: Opcodes 4'h8, 4'h9, 4'hA and 4'hB compute the same value as 4'h0, 4'h1, 4'h2 and 4'h4 respectively, but hold wr_en low. wr_en is high for every other opcode.
- R5: Flags are packed {N,Z,C,V}, with N at bit 3 and V at bit 0. When set_flags is high, N equals result bit 31, and Z is set exactly when the result is zero.
- R6: When set_flags is low, flags_out equals flags_in for every opcode and operand.
- R7: With set_flags high, for the arithmetic opcodes (4'h2 to 4'h7, 4'hA, 4'hB), C is the unsigned carry out of bit 31 for additions, and the inverse of the borrow for subtractions.
- R8: With set_flags high, for the arithmetic opcodes, V is set exactly when a signed overflow occurs.
- R9: With set_flags high, for the logical opcodes (4'h0, 4'h1, 4'h8, 4'h9, 4'hC to 4'hF), C takes shift_carry and V keeps flags_in[0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 4 | Operation select |
| op_a | input | 32 | First operand (register) |
| op_b | input | 32 | Second operand (shifter output) |
| flags_in | input | 4 | Current flags {N,Z,C,V} |
| shift_carry | input | 1 | Carry out of the shifter |
| set_flags | input | 1 | Enables the flag update |
| result | output | 32 | Operation result |
| wr_en | output | 1 | Request to write the result back |
| flags_out | output | 4 | Next flags {N,Z,C,V} |

## Verification
The two functions that meet in one evaluation are the value path and the flag path. A compare must produce correct flags from the same adder while it suppresses the write-back. A carry-chained subtract must consume the incoming carry and at the same moment replace it with its own not-borrow. The bench provokes these cases with directed operands at the signed and unsigned limits, such as equal operands, 0 minus 1, and 0x7FFFFFFF plus 1. Each is driven with the incoming carry both set and clear and with set-flags toggled. Every output field is then compared against a reference that computes subtraction with a widened borrow, not with an inverted-operand adder.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

    typedef enum logic [3:0] {
        OP_AND = 4'h0, OP_EOR = 4'h1, OP_SUB = 4'h2, OP_RSB = 4'h3,
        OP_ADD = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_RSC = 4'h7,
        OP_TST = 4'h8, OP_TEQ = 4'h9, OP_CMP = 4'hA, OP_CMN = 4'hB,
        OP_ORR = 4'hC, OP_MOV = 4'hD, OP_BIC = 4'hE, OP_MVN = 4'hF
    } dp_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } dp_flags_t;

    typedef enum logic [1:0] {
        CIN_ZERO = 2'd0,
        CIN_ONE  = 2'd1,
        CIN_FLAG = 2'd2
    } cin_sel_e;

    typedef struct packed {
        logic     arith;
        logic     swap;
        logic     inv_y;
        cin_sel_e cin;
    } arith_ctl_t;

    function automatic arith_ctl_t decode_arith(dp_op_e op);
        arith_ctl_t ctl;
        ctl = '{arith: 1'b0, swap: 1'b0, inv_y: 1'b0, cin: CIN_ZERO};
        unique case (op)
            OP_ADD, OP_CMN: ctl = '{arith: 1'b1, swap: 1'b0, inv_y: 1'b0, cin: CIN_ZERO};
            OP_ADC:         ctl = '{arith: 1'b1, swap: 1'b0, inv_y: 1'b0, cin: CIN_FLAG};
            OP_SUB, OP_CMP: ctl = '{arith: 1'b1, swap: 1'b0, inv_y: 1'b1, cin: CIN_ONE};
            OP_SBC:         ctl = '{arith: 1'b1, swap: 1'b0, inv_y: 1'b1, cin: CIN_FLAG};
            OP_RSB:         ctl = '{arith: 1'b1, swap: 1'b1, inv_y: 1'b1, cin: CIN_ONE};
            OP_RSC:         ctl = '{arith: 1'b1, swap: 1'b1, inv_y: 1'b1, cin: CIN_FLAG};
            default:        ctl = '{arith: 1'b0, swap: 1'b0, inv_y: 1'b0, cin: CIN_ZERO};
        endcase
        return ctl;
    endfunction

    function automatic logic op_writes_back(dp_op_e op);
        return op[3:2] != 2'b10;
    endfunction

endpackage

// File: rtl/dp_adder.sv
module dp_adder #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout,
    output logic             ovf
);
    localparam int unsigned MSB = WIDTH - 1;

    logic [WIDTH:0] wide;

    always_comb begin
        wide = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin};
        sum  = wide[MSB:0];
        cout = wide[WIDTH];
        ovf  = (x[MSB] == y[MSB]) && (wide[MSB] != x[MSB]);
    end
endmodule

// File: rtl/dp_logic_unit.sv
module dp_logic_unit
    import dp_alu_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  dp_op_e           op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] res
);
    always_comb begin
        unique case (op)
            OP_AND, OP_TST: res = a & b;
            OP_EOR, OP_TEQ: res = a ^ b;
            OP_ORR:         res = a | b;
            OP_MOV:         res = b;
            OP_BIC:         res = a & ~b;
            OP_MVN:         res = ~b;
            default:        res = '0;
        endcase
    end
endmodule

// File: rtl/dp_flag_gen.sv
module dp_flag_gen
    import dp_alu_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic             set_flags,
    input  logic             arith,
    input  logic [WIDTH-1:0] res,
    input  logic             add_cout,
    input  logic             add_ovf,
    input  logic             shift_carry,
    input  dp_flags_t        cur,
    output dp_flags_t        nxt
);
    always_comb begin
        nxt = cur;
        if (set_flags) begin
            nxt.n = res[WIDTH-1];
            nxt.z = (res == '0);
            nxt.c = arith ? add_cout : shift_carry;
            nxt.v = arith ? add_ovf : cur.v;
        end
    end
endmodule

// File: rtl/dp_alu.sv
module dp_alu
    import dp_alu_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic [3:0]        opcode,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [3:0]        flags_in,
    input  logic              shift_carry,
    input  logic              set_flags,
    output logic [DATA_W-1:0] result,
    output logic              wr_en,
    output logic [3:0]        flags_out
);
    dp_op_e            op;
    dp_flags_t         cur_flags;
    dp_flags_t         nxt_flags;
    arith_ctl_t        ctl;
    logic [DATA_W-1:0] add_x;
    logic [DATA_W-1:0] add_y;
    logic              add_cin;
    logic [DATA_W-1:0] add_sum;
    logic              add_cout;
    logic              add_ovf;
    logic [DATA_W-1:0] logic_res;

    assign op        = dp_op_e'(opcode);
    assign cur_flags = dp_flags_t'(flags_in);
    assign ctl       = decode_arith(op);

    always_comb begin
        logic [DATA_W-1:0] first;
        logic [DATA_W-1:0] second;
        first  = ctl.swap ? op_b : op_a;
        second = ctl.swap ? op_a : op_b;
        add_x  = first;
        add_y  = ctl.inv_y ? ~second : second;
        unique case (ctl.cin)
            CIN_ONE:  add_cin = 1'b1;
            CIN_FLAG: add_cin = cur_flags.c;
            default:  add_cin = 1'b0;
        endcase
    end

    dp_adder #(.WIDTH(DATA_W)) u_adder (
        .x    (add_x),
        .y    (add_y),
        .cin  (add_cin),
        .sum  (add_sum),
        .cout (add_cout),
        .ovf  (add_ovf)
    );

    dp_logic_unit #(.WIDTH(DATA_W)) u_logic (
        .op  (op),
        .a   (op_a),
        .b   (op_b),
        .res (logic_res)
    );

    assign result = ctl.arith ? add_sum : logic_res;
    assign wr_en  = op_writes_back(op);

    dp_flag_gen #(.WIDTH(DATA_W)) u_flags (
        .set_flags   (set_flags),
        .arith       (ctl.arith),
        .res         (result),
        .add_cout    (add_cout),
        .add_ovf     (add_ovf),
        .shift_carry (shift_carry),
        .cur         (cur_flags),
        .nxt         (nxt_flags)
    );

    assign flags_out = nxt_flags;
endmodule

// File: rtl/dp_alu_checker.sv
module dp_alu_checker #(
    parameter int unsigned DATA_W = 32
) (
    input logic [3:0]        opcode,
    input logic [DATA_W-1:0] op_a,
    input logic [DATA_W-1:0] op_b,
    input logic [3:0]        flags_in,
    input logic              shift_carry,
    input logic              set_flags,
    input logic [DATA_W-1:0] result,
    input logic              wr_en,
    input logic [3:0]        flags_out
);
    logic is_logical;
    assign is_logical = (opcode <= 4'h1) || (opcode == 4'h8) || (opcode == 4'h9) || (opcode >= 4'hC);

    always_comb begin
        if (!set_flags)
            a_r6_flags_hold: assert (flags_out == flags_in);
        if (set_flags)
            a_r5_neg_msb: assert (flags_out[3] == result[DATA_W-1]);
        if (set_flags)
            a_r5_zero: assert (flags_out[2] == (result == '0));
        if (set_flags && is_logical)
            a_r9_logic_flags: assert (flags_out[1] == shift_carry && flags_out[0] == flags_in[0]);
        if (opcode[3:2] == 2'b10)
            a_r4_no_writeback: assert (!wr_en);
        if (set_flags && opcode == 4'hA)
            a_r7_cmp_carry: assert (flags_out[1] == (op_a >= op_b));
        if (opcode == 4'h3)
            a_r1_reverse_sub: assert (result == op_b - op_a);
    end
endmodule

bind dp_alu dp_alu_checker #(.DATA_W(DATA_W)) u_chk (
    .opcode      (opcode),
    .op_a        (op_a),
    .op_b        (op_b),
    .flags_in    (flags_in),
    .shift_carry (shift_carry),
    .set_flags   (set_flags),
    .result      (result),
    .wr_en       (wr_en),
    .flags_out   (flags_out)
);

// File: tb/dp_alu_tb.sv
module dp_alu_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  opcode = 4'h0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [3:0]  flags_in = 4'h0;
    logic        shift_carry = 1'b0;
    logic        set_flags = 1'b0;
    logic [31:0] result;
    logic        wr_en;
    logic [3:0]  flags_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dp_alu u_dut (
        .opcode(opcode), .op_a(op_a), .op_b(op_b), .flags_in(flags_in),
        .shift_carry(shift_carry), .set_flags(set_flags),
        .result(result), .wr_en(wr_en), .flags_out(flags_out)
    );

    function automatic string req_of(logic [3:0] op);
        if (op == 4'h2 || op == 4'h3 || op == 4'h4 || op == 4'hA || op == 4'hB) return "R1";
        if (op >= 4'h5 && op <= 4'h7) return "R2";
        return "R3";
    endfunction

    task automatic reference(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                             input logic [3:0] fin, input logic sc, input logic sf,
                             output logic [31:0] r, output logic we, output logic [3:0] fo);
        logic [32:0] wide;
        logic        c, v, cin;
        logic        is_ar;
        cin   = fin[1];
        is_ar = 1'b1;
        c = 1'b0; v = 1'b0; r = '0;
        case (op)
            4'h4, 4'hB, 4'h5: begin
                wide = {1'b0, a} + {1'b0, b} + ((op == 4'h5) ? {32'd0, cin} : 33'd0);
                r = wide[31:0]; c = wide[32];
                v = (a[31] == b[31]) && (r[31] != a[31]);
            end
            4'h2, 4'hA, 4'h6: begin
                wide = {1'b0, a} - {1'b0, b} - ((op == 4'h6) ? {32'd0, ~cin} : 33'd0);
                r = wide[31:0]; c = ~wide[32];
                v = (a[31] != b[31]) && (r[31] != a[31]);
            end
            4'h3, 4'h7: begin
                wide = {1'b0, b} - {1'b0, a} - ((op == 4'h7) ? {32'd0, ~cin} : 33'd0);
                r = wide[31:0]; c = ~wide[32];
                v = (b[31] != a[31]) && (r[31] != b[31]);
            end
            default: begin
                is_ar = 1'b0;
                case (op)
                    4'h0, 4'h8: r = a & b;
                    4'h1, 4'h9: r = a ^ b;
                    4'hC:       r = a | b;
                    4'hD:       r = b;
                    4'hE:       r = a & ~b;
                    default:    r = ~b;
                endcase
                c = sc; v = fin[0];
            end
        endcase
        if (!is_ar) begin c = sc; v = fin[0]; end
        we = !(op >= 4'h8 && op <= 4'hB);
        fo = sf ? {r[31], (r == 32'd0), c, v} : fin;
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic [3:0] fin, input logic sc, input logic sf);
        logic [31:0] er;
        logic        ewe;
        logic [3:0]  efo;
        @(negedge clk);
        opcode = op; op_a = a; op_b = b; flags_in = fin; shift_carry = sc; set_flags = sf;
        #1;
        reference(op, a, b, fin, sc, sf, er, ewe, efo);
        check(result === er, req_of(op), "result", result, er);
        check(wr_en === ewe, "R4", "wr_en", {31'd0, wr_en}, {31'd0, ewe});
        if (!sf)
            check(flags_out === efo, "R6", "flags held", {28'd0, flags_out}, {28'd0, efo});
        else begin
            check(flags_out[3:2] === efo[3:2], "R5", "N/Z", {30'd0, flags_out[3:2]}, {30'd0, efo[3:2]});
            check(flags_out[1:0] === efo[1:0], (op >= 4'h2 && op <= 4'h7) || op == 4'hA || op == 4'hB ? "R7/R8" : "R9",
                  "C/V", {30'd0, flags_out[1:0]}, {30'd0, efo[1:0]});
        end
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            failures++; checks++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        // reset state: all inputs zero, AND of zeros, flags held
        @(negedge clk); #1;
        check(result === 32'd0 && wr_en === 1'b1 && flags_out === 4'h0, "R6", "reset state",
              {result[30:0], wr_en}, 32'd1);
        rst = 1'b0;
        // R1 directed
        apply(4'h4, 32'h7FFFFFFF, 32'h1, 4'h0, 1'b0, 1'b1);  // R8 positive overflow
        apply(4'h2, 32'h0, 32'h1, 4'h2, 1'b0, 1'b1);         // R7 borrow clears C
        apply(4'h3, 32'h5, 32'h3, 4'h0, 1'b0, 1'b1);         // R1 reverse
        apply(4'h4, 32'hFFFFFFFF, 32'h1, 4'h0, 1'b0, 1'b1);  // R7 carry and zero
        // R2 with carry set and clear
        for (int c = 0; c < 2; c++) begin
            apply(4'h5, 32'hFFFFFFFF, 32'h0, {2'b00, c[0], 1'b0}, 1'b0, 1'b1);
            apply(4'h6, 32'h10, 32'h10, {2'b00, c[0], 1'b0}, 1'b0, 1'b1);
            apply(4'h7, 32'h80000000, 32'h0, {2'b00, c[0], 1'b0}, 1'b0, 1'b1);
        end
        // R4 compares: equal operands, write suppressed
        apply(4'hA, 32'h1234, 32'h1234, 4'h0, 1'b0, 1'b1);
        apply(4'hB, 32'h80000000, 32'h80000000, 4'h0, 1'b0, 1'b1);
        apply(4'h8, 32'hF0F0F0F0, 32'h0F0F0F0F, 4'h1, 1'b1, 1'b1);
        apply(4'h9, 32'hAAAA5555, 32'hAAAA5555, 4'h1, 1'b0, 1'b1);
        // R3/R9 logical with V preserved
        for (int op = 12; op < 16; op++)
            apply(op[3:0], 32'hC3C3C3C3, 32'h0FF00FF0, 4'h1, 1'b1, 1'b1);
        // R6 set_flags low on an overflowing add
        apply(4'h4, 32'h7FFFFFFF, 32'h1, 4'hA, 1'b1, 1'b0);
        apply(4'hA, 32'h0, 32'h1, 4'h5, 1'b0, 1'b0);
        // random sweep
        for (int i = 0; i < 600; i++)
            apply($urandom_range(15, 0), $urandom, ($urandom_range(3, 0) == 0) ? 32'h7FFFFFFF : $urandom,
                  $urandom_range(15, 0), $urandom_range(1, 0), $urandom_range(3, 0) != 0);
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule